// File: doc/BRIEF.md
# Scan-Mode ADC Readout Sequencer

This block is the host end of a serial link to a multichannel successive-approximation converter that runs its conversions on its own internal clock. On a start request it lowers chip select and sends one 8-bit setup byte, most significant bit first. The byte selects a channel and a scan pattern. The block then parks the serial clock low and waits for the converter to pull its active-low end-of-conversion line down. That line is taken through a synchronizer and an edge detector.

Once the falling edge is seen, the block restarts the serial clock. It reads a stream of 16-bit results, one per conversion, in the order the converter produced them. Each word is presented for one cycle together with the channel it belongs to. After the final bit it releases chip select and holds it high for a programmable gap before it reports itself idle. If the end-of-conversion edge does not come in time, it gives up, releases chip select and raises a sticky error flag.

The serial clock runs at the system clock divided by twice `HALF_DIV`. The outgoing line changes on falling serial-clock edges and the incoming line is sampled on rising ones.

Top module: `adc_scan_ctrl`

## Requirements
- R1: One cycle after `start_i` is accepted, `cs_n_o` is low and `busy_o` is high. Exactly 8 serial-clock pulses follow, and the rising edges carry `cfg_i` on `mosi_o`, bit 7 first. `mosi_o` changes only on a falling serial-clock edge or on the edge that lowers chip select.
- R2: After the eighth setup pulse, `sclk_o` stays low until a falling edge of `eoc_n_i` has been detected.
- R3: The setup byte holds the scan pattern in bits [4:3] and the channel number S in bits [7:5]. Pattern 00 reads one word, 01 reads S+1 words, 10 reads 8 words and 11 reads one word. The read phase gives exactly 16 rising serial-clock edges per word and no others.
- R4: Each word is assembled MSB first from `miso_i` sampled on rising serial-clock edges. The first sample takes the bit present when end-of-conversion fell. Each word is shown on `res_data_o` with `res_valid_o` high for exactly one cycle.
- R5: `res_chan_o` is the word's position k (0, 1, …) for pattern 01, and S for every other pattern.
- R6: `sclk_o` rises only while `cs_n_o` is low. `cs_n_o` rises only with `sclk_o` low, after the last word's final falling edge. After a frame both lines rest at `cs_n_o`=1 and `sclk_o`=0.
- R7: After `cs_n_o` rises, `busy_o` stays high for exactly max(G,1) cycles, where G is `sep_time_i` captured at start, and then falls.
- R8: `tmo_limit_i` is captured at start as L. The wait state is entered on the last setup falling edge. If no end-of-conversion fall has been detected by the (L+1)-th clock after that, the frame ends with no results. With the two-stage synchronizer, a fall of `eoc_n_i` driven d cycles after entering the wait state is taken when d ≤ L−2. A detection that lands on the expiry clock wins over the timeout.
- R9: `err_tmo_o` rises when a wait expires and stays high until the next accepted start clears it.
- R10: `start_i` is ignored while `busy_o` is high. The running frame's results are unchanged and no extra frame follows.
- R11: After reset, `cs_n_o`=1, `sclk_o`=0, `mosi_o`=0, `busy_o`=0, `res_valid_o`=0 and `err_tmo_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a frame (taken only when idle) |
| cfg_i | input | 8 | Setup byte: channel [7:5], scan pattern [4:3] |
| tmo_limit_i | input | 16 | Wait limit for end-of-conversion, in cycles |
| sep_time_i | input | 8 | Minimum chip-select high gap, in cycles |
| eoc_n_i | input | 1 | Converter end-of-conversion, active low, asynchronous |
| miso_i | input | 1 | Serial data from converter |
| cs_n_o | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock, idle low |
| mosi_o | output | 1 | Serial data to converter |
| busy_o | output | 1 | Frame in progress, including the chip-select gap |
| res_valid_o | output | 1 | One-cycle strobe for a finished word |
| res_data_o | output | 16 | Finished result word |
| res_chan_o | output | 3 | Channel tag of the word |
| err_tmo_o | output | 1 | Sticky timeout flag |

## Verification
The timeout expiry and the end-of-conversion detection can land on the same clock, and the detection must take priority. The bench provokes this collision by sweeping the delay of the falling edge across the synchronizer latency around a small wait limit. It judges each case at the ports: either the full result stream with the error flag low, or no serial-clock pulses, no results and the error flag high, with the boundary at d = L−2. All four scan patterns are also swept over every channel, with varied gaps, and a start pulse is injected during a read.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_CFG  = 3'd1,
      ST_WAIT = 3'd2,
      ST_READ = 3'd3,
      ST_SEP  = 3'd4
   } seq_st_e;

   typedef enum logic [1:0] {
      SCAN_ONE     = 2'b00,
      SCAN_UPTO    = 2'b01,
      SCAN_REPEAT  = 2'b10,
      SCAN_ONE_ALT = 2'b11
   } scan_mode_e;

endpackage

// File: rtl/adc_scan_plan.sv
module adc_scan_plan
   import adc_scan_pkg::*;
#(
   parameter int CH_W   = 3,
   parameter int REPEAT = 8,
   parameter int CNT_W  = 4
) (
   input  logic [1:0]       mode,
   input  logic [CH_W-1:0]  sel,
   input  logic [CH_W-1:0]  idx,
   output logic [CNT_W-1:0] count,
   output logic [CH_W-1:0]  tag
);

   generate
      if (REPEAT >= (1 << CNT_W)) begin : g_bad_repeat
         $error("REPEAT does not fit the word counter");
      end
   endgenerate

   always_comb begin
      case (scan_mode_e'(mode))
         SCAN_UPTO: begin
            count = CNT_W'(sel) + CNT_W'(1);
            tag   = idx;
         end
         SCAN_REPEAT: begin
            count = CNT_W'(REPEAT);
            tag   = sel;
         end
         default: begin
            count = CNT_W'(1);
            tag   = sel;
         end
      endcase
   end

endmodule

// File: rtl/adc_scan_sclk_gen.sv
module adc_scan_sclk_gen #(
   parameter int HALF_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic sclk,
   output logic rise_tk,
   output logic fall_tk
);

   logic tick;

   generate
      if (HALF_DIV < 1) begin : g_bad_div
         $error("HALF_DIV must be at least 1");
      end
      if (HALF_DIV == 1) begin : g_nodiv
         assign tick = run;
      end else begin : g_div
         localparam int DIV_W = $clog2(HALF_DIV);
         logic [DIV_W-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               div_q <= '0;
            end else if (!run || div_q == DIV_W'(HALF_DIV - 1)) begin
               div_q <= '0;
            end else begin
               div_q <= div_q + DIV_W'(1);
            end
         end
         assign tick = run && (div_q == DIV_W'(HALF_DIV - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk <= 1'b0;
      end else if (!run) begin
         sclk <= 1'b0;
      end else if (tick) begin
         sclk <= ~sclk;
      end
   end

   assign rise_tk = tick & ~sclk;
   assign fall_tk = tick & sclk;

endmodule

// File: rtl/adc_scan_eoc_sync.sv
module adc_scan_eoc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic eoc_n,
   output logic fall
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sync_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '1;
         last_q <= 1'b1;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], eoc_n};
         last_q <= sync_q[STAGES-1];
      end
   end

   assign fall = last_q & ~sync_q[STAGES-1];

endmodule

// File: rtl/adc_scan_shifter.sv
module adc_scan_shifter #(
   parameter int CFG_W = 8,
   parameter int RES_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CFG_W-1:0] cfg,
   input  logic             tx_shift,
   input  logic             rx_shift,
   input  logic             miso,
   output logic             mosi,
   output logic [RES_W-1:0] rx_next
);

   generate
      if (CFG_W < 2 || RES_W < 2) begin : g_bad_width
         $error("shift widths must be at least 2");
      end
   endgenerate

   logic [CFG_W-1:0] tx_q;
   logic [RES_W-1:0] rx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q <= '0;
      end else if (load) begin
         tx_q <= cfg;
      end else if (tx_shift) begin
         tx_q <= {tx_q[CFG_W-2:0], 1'b0};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_q <= '0;
      end else if (rx_shift) begin
         rx_q <= rx_next;
      end
   end

   assign rx_next = {rx_q[RES_W-2:0], miso};
   assign mosi    = tx_q[CFG_W-1];

endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
   import adc_scan_pkg::*;
#(
   parameter int HALF_DIV    = 2,
   parameter int CFG_W       = 8,
   parameter int RES_W       = 16,
   parameter int CH_W        = 3,
   parameter int REPEAT      = 8,
   parameter int TMO_W       = 16,
   parameter int SEP_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int MODE_LSB    = 3,
   parameter int SEL_LSB     = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [CFG_W-1:0] cfg_i,
   input  logic [TMO_W-1:0] tmo_limit_i,
   input  logic [SEP_W-1:0] sep_time_i,
   input  logic             eoc_n_i,
   input  logic             miso_i,
   output logic             cs_n_o,
   output logic             sclk_o,
   output logic             mosi_o,
   output logic             busy_o,
   output logic             res_valid_o,
   output logic [RES_W-1:0] res_data_o,
   output logic [CH_W-1:0]  res_chan_o,
   output logic             err_tmo_o
);

   localparam int MAXN  = (REPEAT > (1 << CH_W)) ? REPEAT : (1 << CH_W);
   localparam int CNT_W = $clog2(MAXN + 1);
   localparam int BIT_W = $clog2((CFG_W > RES_W) ? CFG_W : RES_W);
   localparam int RDC_W = CNT_W + BIT_W + 1;

   generate
      if (SEL_LSB + CH_W > CFG_W) begin : g_bad_sel
         $error("channel field exceeds setup byte");
      end
      if (MODE_LSB + 2 > SEL_LSB) begin : g_bad_mode
         $error("scan field overlaps channel field");
      end
   endgenerate

   seq_st_e            st_q;
   logic               cs_n_q;
   logic               err_q;
   logic               vld_q;
   logic [RES_W-1:0]   data_q;
   logic [CH_W-1:0]    chan_q;
   logic [1:0]         mode_q;
   logic [CH_W-1:0]    sel_q;
   logic [BIT_W-1:0]   bit_q;
   logic [CNT_W-1:0]   idx_q;
   logic [TMO_W-1:0]   tmo_q;
   logic [TMO_W-1:0]   tmo_cnt_q;
   logic [SEP_W-1:0]   sep_q;
   logic [SEP_W-1:0]   sep_cnt_q;

   logic               run;
   logic               rise_tk;
   logic               fall_tk;
   logic               eoc_fall;
   logic               accept;
   logic [CNT_W-1:0]   word_cnt;
   logic [CH_W-1:0]    word_tag;
   logic [RES_W-1:0]   rx_next;

   assign run    = (st_q == ST_CFG) || (st_q == ST_READ);
   assign accept = (st_q == ST_IDLE) && start_i;

   adc_scan_sclk_gen #(.HALF_DIV(HALF_DIV)) u_sclk (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .sclk    (sclk_o),
      .rise_tk (rise_tk),
      .fall_tk (fall_tk)
   );

   adc_scan_eoc_sync #(.STAGES(SYNC_STAGES)) u_eoc (
      .clk   (clk),
      .rst_n (rst_n),
      .eoc_n (eoc_n_i),
      .fall  (eoc_fall)
   );

   adc_scan_shifter #(.CFG_W(CFG_W), .RES_W(RES_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .cfg      (cfg_i),
      .tx_shift ((st_q == ST_CFG) && fall_tk),
      .rx_shift ((st_q == ST_READ) && rise_tk),
      .miso     (miso_i),
      .mosi     (mosi_o),
      .rx_next  (rx_next)
   );

   adc_scan_plan #(.CH_W(CH_W), .REPEAT(REPEAT), .CNT_W(CNT_W)) u_plan (
      .mode  (mode_q),
      .sel   (sel_q),
      .idx   (idx_q[CH_W-1:0]),
      .count (word_cnt),
      .tag   (word_tag)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         cs_n_q    <= 1'b1;
         err_q     <= 1'b0;
         vld_q     <= 1'b0;
         data_q    <= '0;
         chan_q    <= '0;
         mode_q    <= '0;
         sel_q     <= '0;
         bit_q     <= '0;
         idx_q     <= '0;
         tmo_q     <= '0;
         tmo_cnt_q <= '0;
         sep_q     <= '0;
         sep_cnt_q <= '0;
      end else begin
         vld_q <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  mode_q <= cfg_i[MODE_LSB +: 2];
                  sel_q  <= cfg_i[SEL_LSB +: CH_W];
                  tmo_q  <= tmo_limit_i;
                  sep_q  <= sep_time_i;
                  cs_n_q <= 1'b0;
                  err_q  <= 1'b0;
                  bit_q  <= '0;
                  idx_q  <= '0;
                  st_q   <= ST_CFG;
               end
            end
            ST_CFG: begin
               if (fall_tk) begin
                  if (bit_q == BIT_W'(CFG_W - 1)) begin
                     bit_q     <= '0;
                     tmo_cnt_q <= '0;
                     st_q      <= ST_WAIT;
                  end else begin
                     bit_q <= bit_q + BIT_W'(1);
                  end
               end
            end
            ST_WAIT: begin
               if (eoc_fall) begin
                  st_q <= ST_READ;
               end else if (tmo_cnt_q >= tmo_q) begin
                  err_q     <= 1'b1;
                  cs_n_q    <= 1'b1;
                  sep_cnt_q <= SEP_W'(1);
                  st_q      <= ST_SEP;
               end else begin
                  tmo_cnt_q <= tmo_cnt_q + TMO_W'(1);
               end
            end
            ST_READ: begin
               if (rise_tk) begin
                  if (bit_q == BIT_W'(RES_W - 1)) begin
                     bit_q  <= '0;
                     vld_q  <= 1'b1;
                     data_q <= rx_next;
                     chan_q <= word_tag;
                     idx_q  <= idx_q + CNT_W'(1);
                  end else begin
                     bit_q <= bit_q + BIT_W'(1);
                  end
               end
               if (fall_tk && idx_q == word_cnt) begin
                  cs_n_q    <= 1'b1;
                  sep_cnt_q <= SEP_W'(1);
                  st_q      <= ST_SEP;
               end
            end
            ST_SEP: begin
               if (sep_cnt_q >= sep_q) begin
                  st_q <= ST_IDLE;
               end else begin
                  sep_cnt_q <= sep_cnt_q + SEP_W'(1);
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign cs_n_o      = cs_n_q;
   assign busy_o      = (st_q != ST_IDLE);
   assign res_valid_o = vld_q;
   assign res_data_o  = data_q;
   assign res_chan_o  = chan_q;
   assign err_tmo_o   = err_q;

   // Support counters for the checks below.
   logic [BIT_W:0]   cfg_rises_q;
   logic [RDC_W-1:0] rd_rises_q;
   logic [SEP_W:0]   hi_run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_rises_q <= '0;
         rd_rises_q  <= '0;
         hi_run_q    <= '0;
      end else begin
         if (accept) begin
            cfg_rises_q <= '0;
            rd_rises_q  <= '0;
         end else begin
            if (st_q == ST_CFG && rise_tk) cfg_rises_q <= cfg_rises_q + (BIT_W+1)'(1);
            if (st_q == ST_READ && rise_tk) rd_rises_q <= rd_rises_q + RDC_W'(1);
         end
         if (cs_n_o && busy_o) hi_run_q <= hi_run_q + (SEP_W+1)'(1);
         else hi_run_q <= '0;
      end
   end

   assert_cfg_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_WAIT && $past(st_q) == ST_CFG) |-> cfg_rises_q == (BIT_W+1)'(CFG_W));

   assert_wait_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_WAIT) |-> !sclk_o);

   assert_read_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cs_n_o) && !err_tmo_o) |-> rd_rises_q == RDC_W'(word_cnt) * RDC_W'(RES_W));

   assert_valid_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid_o |=> !res_valid_o);

   assert_sclk_framed_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk_o) |-> !cs_n_o);

   assert_cs_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n_o) |-> !sclk_o);

   assert_sep_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> hi_run_q >= (SEP_W+1)'(sep_q));

   assert_busy_cover_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n_o |-> busy_o);

endmodule

// File: tb/adc_scan_ctrl_bench.sv
module adc_scan_ctrl_bench;

   localparam int HALF = 2;
   localparam int SYNC = 2;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        start_i;
   logic [7:0]  cfg_i;
   logic [15:0] tmo_limit_i;
   logic [7:0]  sep_time_i;
   logic        eoc_n_i;
   logic        miso_i;
   logic        cs_n_o, sclk_o, mosi_o, busy_o, res_valid_o, err_tmo_o;
   logic [15:0] res_data_o;
   logic [2:0]  res_chan_o;

   always #10 clk = ~clk;

   adc_scan_ctrl #(.HALF_DIV(HALF), .SYNC_STAGES(SYNC)) u_adc_scan_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .cfg_i       (cfg_i),
      .tmo_limit_i (tmo_limit_i),
      .sep_time_i  (sep_time_i),
      .eoc_n_i     (eoc_n_i),
      .miso_i      (miso_i),
      .cs_n_o      (cs_n_o),
      .sclk_o      (sclk_o),
      .mosi_o      (mosi_o),
      .busy_o      (busy_o),
      .res_valid_o (res_valid_o),
      .res_data_o  (res_data_o),
      .res_chan_o  (res_chan_o),
      .err_tmo_o   (err_tmo_o)
   );

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   // converter model state
   logic [15:0] words [0:7];
   logic [2:0]  tags  [0:7];
   int   n_exp = 1;
   bit   rd_on = 0;
   int   bi = 0, cfg_rises = 0, post_rises = 0, vcnt = 0, vbad = 0;
   int   sep_seen = 0, mosi_glitch = 0, stray = 0;
   logic [7:0] cfg_cap = 8'h00;
   logic sclk_p = 1'b0, cs_p = 1'b1, mosi_p = 1'b0;

   assign miso_i = (bi < n_exp * 16) ? words[bi / 16][15 - (bi % 16)] : 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!cs_n_o && cs_p) begin
            cfg_rises = 0; post_rises = 0; bi = 0; vcnt = 0; vbad = 0;
            sep_seen = 0; mosi_glitch = 0;
         end else if (mosi_o != mosi_p && !(!sclk_o && sclk_p)) begin
            mosi_glitch++;
         end
         if (sclk_o && !sclk_p) begin
            if (cs_n_o) stray++;
            else if (cfg_rises < 8) begin
               cfg_cap = {cfg_cap[6:0], mosi_o};
               cfg_rises++;
            end else post_rises++;
         end
         if (!sclk_o && sclk_p && rd_on) bi++;
         if (res_valid_o) begin
            if (vcnt < n_exp) begin
               if (res_data_o !== words[vcnt] || res_chan_o !== tags[vcnt]) vbad++;
            end else vbad++;
            vcnt++;
         end
         if (cs_n_o && busy_o) sep_seen++;
      end
      sclk_p = sclk_o; cs_p = cs_n_o; mosi_p = mosi_o;
   end

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   int frame_id = 0;

   task automatic run_frame(input int mode, input int sel, input int sep, input int tmo,
                            input int d, input bit drop, input bit poke);
      logic [7:0] cfg;
      bit ok;
      int gap;
      cfg = {sel[2:0], mode[1:0], 3'(frame_id)};
      n_exp = (mode == 1) ? sel + 1 : (mode == 2) ? 8 : 1;
      for (int k = 0; k < 8; k++) begin
         words[k] = 16'(frame_id * 16'h0259) ^ 16'(k * 16'h1357) ^ 16'hA5C3;
         tags[k]  = (mode == 1) ? 3'(k) : 3'(sel);
      end
      frame_id++;
      ok  = drop && (d <= tmo - SYNC);
      gap = (sep < 1) ? 1 : sep;
      rd_on = 0;
      step();
      cfg_i = cfg; sep_time_i = 8'(sep); tmo_limit_i = 16'(tmo); start_i = 1'b1;
      step();
      start_i = 1'b0;
      chk(!cs_n_o && busy_o, "R1 frame start", {cs_n_o, busy_o}, 2'b01);
      chk(err_tmo_o == 1'b0, "R9 error cleared by start", err_tmo_o, 0);
      while (!(cfg_rises == 8 && !sclk_o)) step();
      chk(cfg_cap == cfg, "R1 setup byte", cfg_cap, cfg);
      repeat (d) step();
      if (drop) begin
         eoc_n_i = 1'b0;
         rd_on   = 1;
      end
      if (poke) begin
         repeat (5) step();
         cfg_i = ~cfg; start_i = 1'b1;
         step();
         start_i = 1'b0;
      end
      while (busy_o) step();
      eoc_n_i = 1'b1;
      rd_on   = 0;
      chk(post_rises == (ok ? n_exp * 16 : 0), ok ? "R3 read clocks" : "R2 no clocks on timeout",
          post_rises, ok ? n_exp * 16 : 0);
      chk(vcnt == (ok ? n_exp : 0), "R4 word count", vcnt, ok ? n_exp : 0);
      chk(vbad == 0, "R4 R5 data and channel tags", vbad, 0);
      chk(err_tmo_o == !ok, "R8 timeout outcome", err_tmo_o, !ok);
      chk(sep_seen == gap, "R7 chip-select gap", sep_seen, gap);
      chk(mosi_glitch == 0, "R1 mosi changes on falling edge", mosi_glitch, 0);
      chk(cs_n_o && !sclk_o, "R6 rest levels", {cs_n_o, sclk_o}, 2'b10);
      if (!ok && drop) chk(err_tmo_o == 1'b1, "R9 flag held", err_tmo_o, 1);
      if (poke) begin
         repeat (4) step();
         chk(cs_n_o && !busy_o && vcnt == n_exp, "R10 start ignored while busy",
             {cs_n_o, busy_o}, 2'b10);
      end
   endtask

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; start_i = 1'b0; cfg_i = 8'h00; tmo_limit_i = 16'd0;
      sep_time_i = 8'd0; eoc_n_i = 1'b1;
      repeat (3) step();
      chk(cs_n_o && !sclk_o && !mosi_o && !busy_o && !res_valid_o && !err_tmo_o,
          "R11 reset state", {cs_n_o, sclk_o, mosi_o, busy_o, res_valid_o, err_tmo_o}, 6'b100000);
      rst_n = 1'b1;
      repeat (3) step();
      // sweep of scan pattern and channel
      for (int m = 0; m < 4; m++) begin
         for (int s = 0; s < 8; s++) begin
            run_frame(m, s, (m * 8 + s) % 5, 300, s % 3, 1'b1, s == 5);
         end
      end
      // collision of expiry and detection around limit 12
      for (int d = 8; d <= 12; d++) run_frame(1, 2, 3, 12, d, 1'b1, 1'b0);
      // no end-of-conversion, then recovery
      run_frame(1, 7, 2, 20, 0, 1'b0, 1'b0);
      run_frame(2, 4, 40, 300, 1, 1'b1, 1'b0);
      run_frame(0, 6, 0, 1, 0, 1'b1, 1'b0);
      run_frame(3, 1, 1, 0, 0, 1'b1, 1'b0);
      run_frame(1, 3, 7, 300, 2, 1'b1, 1'b0);
      chk(stray == 0, "R6 no clock with chip select high", stray, 0);
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule